// File: doc/BRIEF.md
# Indexed Interrupt Redirection Table

This block routes 24 interrupt inputs to processors. Software reaches it through a two-register window on a 32-bit bus. A write at byte offset 0x00 selects a register index. Reads and writes at byte offset 0x10 then act on whichever register that index currently selects. The block has 24 routing entries of 64 bits each. Software reaches each entry as two 32-bit halves. An entry holds the vector to deliver, a mask bit and the ID of the destination processor.

When an unmasked input line goes from low to high, the block marks that line as pending. A pending line is then offered as a request that carries the entry's vector and destination ID. The request is offered over a valid/ready handshake. It stays offered until it is accepted, and acceptance clears the pending mark. When several lines are pending, the lowest-numbered line is offered first.

Top module: `irq_router`

## Requirements
- R1: A bus write at byte offset 0x00 loads the 8-bit index register, and a bus read at offset 0x00 returns it zero-extended. Data-window accesses at offset 0x10 act on the register that the index selects.
- R2: Entry n is reached at index 0x10+2n for bits 31:0 and at index 0x11+2n for bits 63:32. A write to either half can be read back unchanged.
- R3: After reset, the index register is 0 and no request is offered. Every entry reads 0x00010000 in its low half (mask set) and 0 in its high half.
- R4: Index 0x01 reads 0x00170000, with bits 23:16 equal to the highest entry number, 23. Writes to it have no effect.
- R5: Indices 0x00, 0x02 to 0x0F and 0x40 and above read as zero. Writes to them change no entry.
- R6: A rising edge on input n is delivered only when entry n has bit 16 (mask) clear. The request appears on the second rising clock edge after the input edge is sampled. It carries req_vector equal to entry bits 7:0 and req_dest equal to entry bits 63:56.
- R7: An edge that arrives while its entry is masked is dropped. Clearing the mask afterwards produces no request.
- R8: An offered request holds its valid, vector and destination until req_ready is seen high. req_valid is low in the cycle after acceptance. Each edge yields exactly one request, so a line that stays high does not repeat.
- R9: Among pending unmasked entries, the lowest-numbered one is offered first.
- R10: Read data appears on bus_rdata in the cycle after the read strobe. Byte offsets other than 0x00 and 0x10 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 24 | Interrupt input lines |
| req_valid | output | 1 | Delivery request offered |
| req_ready | input | 1 | Delivery request accepted |
| req_vector | output | 8 | Vector of the offered request |
| req_dest | output | 8 | Destination processor ID |

## Verification
The bench aims at the places where the halves and indices could be swapped or could alias. One such case is the first index past the last entry, 0x40. A decoder that wraps the entry number would let a write there corrupt an entry, and the bench would read back a changed entry. The bench raises edges on masked lines and then unmasks them. A design that latched masked edges would then deliver a stale request. Three lines are raised in the same cycle, and their requests must come out in ascending order. A priority encoder that favours high-numbered lines would offer entry 20 first. A line held high after its request has been accepted must stay silent. A level-sensitive design would offer the request again.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned IDX_W = 8;
  localparam logic [7:0] OFF_INDEX = 8'h00;
  localparam logic [7:0] OFF_WINDOW = 8'h10;
  localparam logic [7:0] IDX_VERSION = 8'h01;
  localparam logic [7:0] IDX_TABLE = 8'h10;
  localparam int unsigned MASK_BIT = 16;
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 24,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  localparam int unsigned EW = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [IDX_W-1:0]   sel_o,
  output logic [NUM_IRQ-1:0] mask_o,
  input  logic [EW-1:0]      look_idx,
  output logic [7:0]         look_vector,
  output logic [7:0]         look_dest
);
  localparam logic [IDX_W-1:0] TBL_END = IDX_W'(IDX_TABLE + 2 * NUM_IRQ);
  localparam logic [DW-1:0] VER_WORD = DW'(NUM_IRQ - 1) << 16;
  localparam logic [DW-1:0] LO_RESET = DW'(1) << MASK_BIT;

  logic [IDX_W-1:0] sel_q;
  logic [DW-1:0] lo_mem [NUM_IRQ];
  logic [DW-1:0] hi_mem [NUM_IRQ];
  logic [NUM_IRQ-1:0] mask_q;
  logic [DW-1:0] rd_mux;
  logic in_tbl;
  logic [IDX_W-1:0] rel;
  logic [EW-1:0] ent;
  logic hi_half;

  assign in_tbl = (sel_q >= IDX_TABLE) && (sel_q < TBL_END);
  assign rel = sel_q - IDX_TABLE;
  assign ent = rel[EW:1];
  assign hi_half = rel[0];

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFF_INDEX)) begin
      rd_mux = DW'(sel_q);
    end else if (bus_addr == AW'(OFF_WINDOW)) begin
      if (sel_q == IDX_VERSION) rd_mux = VER_WORD;
      else if (in_tbl) rd_mux = hi_half ? hi_mem[ent] : lo_mem[ent];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      mask_q    <= '1;
      bus_rdata <= '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        lo_mem[i] <= LO_RESET;
        hi_mem[i] <= '0;
      end
    end else begin
      if (bus_wr && bus_addr == AW'(OFF_INDEX)) sel_q <= bus_wdata[IDX_W-1:0];
      if (bus_wr && bus_addr == AW'(OFF_WINDOW) && in_tbl) begin
        if (hi_half) begin
          hi_mem[ent] <= bus_wdata;
        end else begin
          lo_mem[ent] <= bus_wdata;
          mask_q[ent] <= bus_wdata[MASK_BIT];
        end
      end
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign sel_o = sel_q;
  assign mask_o = mask_q;
  assign look_vector = lo_mem[look_idx][7:0];
  assign look_dest = hi_mem[look_idx][DW-1 -: 8];
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned NUM_IRQ = 24,
  localparam int unsigned EW = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic               clr_en,
  input  logic [EW-1:0]      clr_idx,
  output logic [NUM_IRQ-1:0] pend
);
  logic [NUM_IRQ-1:0] prev_q;
  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] rise;
  logic [NUM_IRQ-1:0] clr_vec;

  assign rise = irq_in & ~prev_q & ~mask;
  assign clr_vec = clr_en ? (NUM_IRQ'(1) << clr_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq_in;
      pend_q <= (pend_q & ~clr_vec) | rise;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NUM_IRQ = 24,
  localparam int unsigned EW = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] cand,
  output logic               found,
  output logic [EW-1:0]      idx
);
  always_comb begin
    found = 1'b0;
    idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx = EW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int unsigned NUM_IRQ = 24,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  localparam int unsigned EW = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [7:0]         req_vector,
  output logic [7:0]         req_dest
);
  logic [7:0] sel_w;
  logic [NUM_IRQ-1:0] mask_w;
  logic [NUM_IRQ-1:0] pend_w;
  logic [NUM_IRQ-1:0] cand_w;
  logic found_w;
  logic [EW-1:0] pick_w;
  logic [7:0] look_vec_w;
  logic [7:0] look_dest_w;
  logic valid_q;
  logic [7:0] vec_q;
  logic [7:0] dest_q;
  logic [EW-1:0] req_idx_q;
  logic accept;

  irq_regfile #(.NUM_IRQ(NUM_IRQ), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_o(sel_w), .mask_o(mask_w),
    .look_idx(pick_w), .look_vector(look_vec_w), .look_dest(look_dest_w)
  );

  assign accept = valid_q && req_ready;

  irq_pending #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask(mask_w),
    .clr_en(accept), .clr_idx(req_idx_q), .pend(pend_w)
  );

  assign cand_w = pend_w & ~mask_w;

  irq_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .cand(cand_w), .found(found_w), .idx(pick_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      vec_q     <= '0;
      dest_q    <= '0;
      req_idx_q <= '0;
    end else if (accept) begin
      valid_q <= 1'b0;
    end else if (!valid_q && found_w) begin
      valid_q   <= 1'b1;
      vec_q     <= look_vec_w;
      dest_q    <= look_dest_w;
      req_idx_q <= pick_w;
    end
  end

  assign req_valid = valid_q;
  assign req_vector = vec_q;
  assign req_dest = dest_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int unsigned NUM_IRQ = 24,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 8,
  localparam int unsigned EW = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [7:0]         req_vector,
  input logic [7:0]         req_dest,
  input logic               bus_rd,
  input logic [AW-1:0]      bus_addr,
  input logic [DW-1:0]      bus_rdata,
  input logic [7:0]         sel,
  input logic [NUM_IRQ-1:0] mask,
  input logic [NUM_IRQ-1:0] cand,
  input logic [EW-1:0]      req_idx
);
  localparam logic [DW-1:0] VER_WORD = DW'(NUM_IRQ - 1) << 16;
  logic [NUM_IRQ-1:0] mask_prev;
  logic [NUM_IRQ-1:0] cand_prev;
  logic [NUM_IRQ-1:0] below;

  always_ff @(posedge clk) begin
    mask_prev <= mask;
    cand_prev <= cand;
  end

  assign below = (NUM_IRQ'(1) << req_idx) - NUM_IRQ'(1);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_vector) && $stable(req_dest));

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_valid);

  p_unmasked_r7: assert property (@(posedge clk) disable iff (rst)
    req_valid && !$past(req_valid) |-> !mask_prev[req_idx]);

  p_lowest_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid && !$past(req_valid) |-> cand_prev[req_idx] && ((cand_prev & below) == '0));

  p_version_r4: assert property (@(posedge clk) disable iff (rst)
    bus_rd && bus_addr == AW'(8'h10) && sel == 8'h01 |=> bus_rdata == VER_WORD);
endmodule

bind irq_router irq_router_chk #(.NUM_IRQ(NUM_IRQ), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_vector(req_vector), .req_dest(req_dest), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .sel(sel_w), .mask(mask_w),
  .cand(cand_w), .req_idx(req_idx_q)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic req_valid;
  logic req_ready = 1'b0;
  logic [7:0] req_vector;
  logic [7:0] req_dest;

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_router dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector), .req_dest(req_dest)
  );

  function automatic logic [7:0] lo_index(int e); return 8'(8'h10 + 2 * e); endfunction
  function automatic logic [7:0] hi_index(int e); return 8'(8'h11 + 2 * e); endfunction
  function automatic logic [31:0] version_word(); return 32'(N - 1) << 16; endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(8'h00, 32'(idx)); bus_write(8'h10, d);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] d);
    bus_write(8'h00, 32'(idx)); bus_read(8'h10, d);
  endtask

  task automatic set_entry(input int e, input logic [7:0] vec, input logic [7:0] dst, input bit msk);
    m_lo[e] = {15'h0, msk, 8'h0, vec};
    m_hi[e] = {dst, 24'h0};
    reg_write(lo_index(e), m_lo[e]);
    reg_write(hi_index(e), m_hi[e]);
  endtask

  task automatic expect_req(input int e, input string tag);
    check(req_valid === 1'b1, {tag, " valid"}, 32'(req_valid), 32'd1);
    check(req_vector === m_lo[e][7:0], {tag, " vector"}, 32'(req_vector), 32'(m_lo[e][7:0]));
    check(req_dest === m_hi[e][31:24], {tag, " dest"}, 32'(req_dest), 32'(m_hi[e][31:24]));
  endtask

  task automatic accept_req();
    req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    check(req_valid === 1'b0, "R8 valid low after accept", 32'(req_valid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_valid === 1'b0, "R3 no request after reset", 32'(req_valid), 32'd0);
    bus_read(8'h00, d);
    check(d === 32'h0, "R3 index after reset", d, 32'h0);
    for (int e = 0; e < N; e += 7) begin
      reg_read(lo_index(e), d); check(d === 32'h0001_0000, "R3 low half reset", d, 32'h0001_0000);
      reg_read(hi_index(e), d); check(d === 32'h0, "R3 high half reset", d, 32'h0);
    end

    // R1 index readback and data-window reach
    bus_write(8'h00, 32'h0000_003B);
    bus_read(8'h00, d);
    check(d === 32'h3B, "R1 index readback", d, 32'h3B);

    // R2 random table writes with readback
    for (int k = 0; k < 30; k++) begin
      int e = int'($urandom % N);
      int f = int'($urandom % N);
      m_lo[e] = $urandom; m_hi[e] = $urandom;
      reg_write(lo_index(e), m_lo[e]);
      reg_write(hi_index(e), m_hi[e]);
      reg_read(lo_index(f), d); check(d === m_lo[f], "R2 low half readback", d, m_lo[f]);
      reg_read(hi_index(f), d); check(d === m_hi[f], "R2 high half readback", d, m_hi[f]);
    end

    // R4 version register, write ignored
    reg_read(8'h01, d); check(d === version_word(), "R4 version", d, version_word());
    reg_write(8'h01, 32'hFFFF_FFFF);
    reg_read(8'h01, d); check(d === version_word(), "R4 version write ignored", d, version_word());

    // R5 reserved indices
    reg_write(8'h40, 32'hFFFF_FFFF);
    reg_write(8'h02, 32'hFFFF_FFFF);
    reg_read(8'h40, d); check(d === 32'h0, "R5 index 0x40 reads zero", d, 32'h0);
    reg_read(8'h02, d); check(d === 32'h0, "R5 index 0x02 reads zero", d, 32'h0);
    reg_read(8'h00, d); check(d === 32'h0, "R5 index 0x00 reads zero", d, 32'h0);
    reg_read(lo_index(0), d); check(d === m_lo[0], "R5 entry 0 untouched", d, m_lo[0]);
    reg_read(hi_index(N - 1), d); check(d === m_hi[N - 1], "R5 last entry untouched", d, m_hi[N - 1]);

    // R10 other offsets
    bus_write(8'h00, 32'h0000_0011);
    bus_write(8'h08, 32'h0000_0022);
    bus_read(8'h08, d); check(d === 32'h0, "R10 offset 0x08 reads zero", d, 32'h0);
    bus_read(8'h00, d); check(d === 32'h11, "R10 write at 0x08 ignored", d, 32'h11);

    // Mask every entry before the delivery tests
    for (int e = 0; e < N; e++) set_entry(e, 8'h20 + 8'(e), 8'h0, 1'b1);

    // R6 random single deliveries
    for (int k = 0; k < 10; k++) begin
      int e = int'($urandom % N);
      set_entry(e, 8'($urandom), 8'($urandom), 1'b0);
      @(negedge clk); irq_in[e] = 1'b1;
      @(negedge clk);
      check(req_valid === 1'b0, "R6 no request one cycle after edge", 32'(req_valid), 32'd0);
      @(negedge clk);
      expect_req(e, "R6 delivery");
      accept_req();
      irq_in[e] = 1'b0;
      set_entry(e, m_lo[e][7:0], m_hi[e][31:24], 1'b1);
    end

    // R7 masked edge dropped, unmasking later gives nothing
    @(negedge clk); irq_in[5] = 1'b1;
    repeat (4) @(negedge clk);
    check(req_valid === 1'b0, "R7 masked edge no request", 32'(req_valid), 32'd0);
    set_entry(5, 8'h55, 8'h05, 1'b0);
    repeat (4) @(negedge clk);
    check(req_valid === 1'b0, "R7 unmask after edge no request", 32'(req_valid), 32'd0);
    irq_in[5] = 1'b0;
    set_entry(5, 8'h55, 8'h05, 1'b1);

    // R9 priority and R8 hold
    set_entry(3, 8'hA3, 8'h13, 1'b0);
    set_entry(7, 8'hA7, 8'h17, 1'b0);
    set_entry(20, 8'hB4, 8'h34, 1'b0);
    @(negedge clk); irq_in[20] = 1'b1; irq_in[7] = 1'b1; irq_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    expect_req(3, "R9 lowest first");
    repeat (3) @(negedge clk);
    expect_req(3, "R8 held without ready");
    accept_req();
    @(negedge clk);
    expect_req(7, "R9 second entry");
    accept_req();
    @(negedge clk);
    expect_req(20, "R9 third entry");
    accept_req();
    repeat (5) @(negedge clk);
    check(req_valid === 1'b0, "R8 held level does not repeat", 32'(req_valid), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule